// File: doc/BRIEF.md
# Level-Shifted Multicarrier PWM Generator

This block turns one phase's modulating reference into switch commands for a five-level cascaded H-bridge phase made of two series bridges. Four triangular carriers share one frequency and one amplitude. Each carrier sits on its own offset, so the four together tile the whole reference span without gaps. The reference is compared against every carrier. The number of carriers it exceeds selects one of five output levels, and that level is decoded into the eight gate commands of the two bridges.

A two-bit disposition input picks one of three carrier arrangements. In the first, all carriers run in phase. In the second, the carriers below the midpoint run in antiphase to those above it. In the third, every carrier is in antiphase with its neighbours. The half period of the triangle, in clock cycles, is an input. For a 10 kHz carrier on a 100 MHz clock it is set to 5000. The disposition and the half period are captured during reset and again only at a carrier valley, so a change made mid-period never produces a runt pulse. A three-phase drive uses three instances with references shifted by 120°.

Top module: `lspwm_phase`

## Requirements
- R1: While `rst` is high, the outputs settle on the next clock edge to `level_o` = 0 and `gate_o` = 8'hAA, which means every lower switch is on and every upper switch is off. The carrier is held at its valley, and `mode_i` and `half_i` are captured.
- R2: The carrier counter is a symmetric triangle. After reset it counts 0, 1, …, H, H−1, …, 1 and then returns to 0, so one period lasts 2H cycles. H is the captured `half_i`, and a value of 0 is treated as 1.
- R3: Carrier k (k = 0..3, 0 lowest) equals k·H plus a band value in 0..H. The band value is the triangle t, or H−t when that band is inverted. The reference spans 0..4H, and 2H is the zero reference.
- R4: With `mode_i` = 0 (phase disposition), no band is inverted. The spare code 3 behaves the same way.
- R5: With `mode_i` = 1 (phase opposition), bands 0 and 1 are inverted and bands 2 and 3 are not.
- R6: With `mode_i` = 2 (alternate opposition), bands 1 and 3 are inverted and bands 0 and 2 are not.
- R7: Each rising edge registers n−2 into `level_o` as a signed value. Here n is the number of carriers that `ref_i`, sampled at that edge, strictly exceeds, using the carrier value held before that edge.
- R8: Bridge j (j = 0 for bands 0–1, j = 1 for bands 2–3) uses `gate_o[4j+3:4j]` = {leg B low, leg B high, leg A low, leg A high}. If the reference exceeds both of the bridge's carriers, the bridge gives +1 (A high, B low). If it exceeds only the lower carrier, the bridge gives 0 (both legs low). If it exceeds neither, the bridge gives −1 (A low, B high).
- R9: On every cycle, each leg's high and low gates are complementary.
- R10: A new `mode_i` or `half_i` takes effect only from the first valley of the carrier after the change. The period in progress completes with the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Carrier disposition: 0 in phase, 1 opposition about the midpoint, 2 alternate opposition |
| half_i | input | HALF_W (13) | Triangle half period in clock cycles |
| ref_i | input | REF_W (16) | Modulating reference, 0..4·H, midpoint 2·H |
| gate_o | output | 4·BRIDGES (8) | Gate commands, four per bridge as in R8 |
| level_o | output | LVL_W (4) | Signed phase output level, −2..+2 |

## Verification
The hardest case to reach from the ports is a setting change that arrives in the middle of a carrier period. For that case the bench must show that the old disposition and the old half period survive until the next valley. The bench drives `mode_i` and `half_i` a few cycles after a valley, with the reference held inside a band whose inversion differs between the old and new modes. This makes a setting applied too early visible on `level_o` within the same period. A reference model in the bench tracks its own phase counter, picks up the new settings only at the valley, and compares the level and all eight gates on every cycle.

// File: rtl/lspwm_pkg.sv
package lspwm_pkg;
  // Carrier disposition codes; the spare code behaves as in-phase.
  typedef enum logic [1:0] {
    DISP_PD    = 2'd0,
    DISP_POD   = 2'd1,
    DISP_APOD  = 2'd2,
    DISP_SPARE = 2'd3
  } disp_e;
endpackage

// File: rtl/lspwm_tri.sv
module lspwm_tri
  import lspwm_pkg::*;
#(
  parameter int HALF_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HALF_W-1:0] half_i,
  input  disp_e             mode_i,
  output logic [HALF_W-1:0] tri_o,
  output logic [HALF_W-1:0] half_o,
  output disp_e             mode_o,
  output logic              dn_o
);
  localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

  logic [HALF_W-1:0] half_safe;
  assign half_safe = (half_i == '0) ? ONE : half_i;

  // Up/down counter; settings reload only on the step into the valley.
  always_ff @(posedge clk) begin
    if (rst) begin
      tri_o  <= '0;
      dn_o   <= 1'b0;
      half_o <= half_safe;
      mode_o <= mode_i;
    end else if (!dn_o) begin
      tri_o <= tri_o + ONE;
      if (tri_o == half_o - ONE) dn_o <= 1'b1;
    end else begin
      tri_o <= tri_o - ONE;
      if (tri_o == ONE) begin
        dn_o   <= 1'b0;
        half_o <= half_safe;
        mode_o <= mode_i;
      end
    end
  end
endmodule

// File: rtl/lspwm_bands.sv
module lspwm_bands
  import lspwm_pkg::*;
#(
  parameter int HALF_W = 13,
  parameter int BANDS  = 4,
  parameter int REF_W  = HALF_W + 3
) (
  input  logic [HALF_W-1:0] tri_i,
  input  logic [HALF_W-1:0] half_i,
  input  disp_e             mode_i,
  input  logic [REF_W-1:0]  ref_i,
  output logic [BANDS-1:0]  above_o
);
  logic [REF_W-1:0] tri_x, half_x, mirror_x;
  assign tri_x    = REF_W'(tri_i);
  assign half_x   = REF_W'(half_i);
  assign mirror_x = half_x - tri_x;

  for (genvar k = 0; k < BANDS; k++) begin : g_band
    logic             flip;
    logic [REF_W-1:0] base, car;

    always_comb begin
      case (mode_i)
        DISP_POD:  flip = (k < BANDS / 2);
        DISP_APOD: flip = (k % 2 == 1);
        default:   flip = 1'b0;
      endcase
    end

    assign base       = REF_W'(k) * half_x;
    assign car        = base + (flip ? mirror_x : tri_x);
    assign above_o[k] = ref_i > car;
  end
endmodule

// File: rtl/lspwm_gates.sv
module lspwm_gates #(
  parameter int BRIDGES = 2,
  parameter int LVL_W   = $clog2(2 * BRIDGES + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [2*BRIDGES-1:0]    above_i,
  output logic [4*BRIDGES-1:0]    gate_o,
  output logic signed [LVL_W-1:0] level_o
);
  localparam int BANDS = 2 * BRIDGES;

  logic [LVL_W-1:0]     ones;
  logic [4*BRIDGES-1:0] gate_d;

  always_comb begin
    ones = '0;
    for (int i = 0; i < BANDS; i++) ones = ones + LVL_W'(above_i[i]);
  end

  // Per bridge: {B low, B high, A low, A high}.
  for (genvar j = 0; j < BRIDGES; j++) begin : g_bridge
    assign gate_d[4*j+0] =  above_i[2*j+1];
    assign gate_d[4*j+1] = ~above_i[2*j+1];
    assign gate_d[4*j+2] = ~above_i[2*j];
    assign gate_d[4*j+3] =  above_i[2*j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_o  <= {BRIDGES{4'b1010}};
      level_o <= '0;
    end else begin
      gate_o  <= gate_d;
      level_o <= $signed(ones - LVL_W'(BRIDGES));
    end
  end
endmodule

// File: rtl/lspwm_phase.sv
module lspwm_phase
  import lspwm_pkg::*;
#(
  parameter int  HALF_W  = 13,
  parameter int  BRIDGES = 2,
  localparam int BANDS   = 2 * BRIDGES,
  localparam int REF_W   = HALF_W + $clog2(BANDS) + 1,
  localparam int LVL_W   = $clog2(BANDS + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              mode_i,
  input  logic [HALF_W-1:0]       half_i,
  input  logic [REF_W-1:0]        ref_i,
  output logic [4*BRIDGES-1:0]    gate_o,
  output logic signed [LVL_W-1:0] level_o
);
  logic [HALF_W-1:0] tri_w, half_w;
  logic              dn_w;
  disp_e             mode_w;
  logic [BANDS-1:0]  above_w;

  lspwm_tri #(.HALF_W(HALF_W)) u_tri (
    .clk    (clk),
    .rst    (rst),
    .half_i (half_i),
    .mode_i (disp_e'(mode_i)),
    .tri_o  (tri_w),
    .half_o (half_w),
    .mode_o (mode_w),
    .dn_o   (dn_w)
  );

  lspwm_bands #(.HALF_W(HALF_W), .BANDS(BANDS), .REF_W(REF_W)) u_bands (
    .tri_i   (tri_w),
    .half_i  (half_w),
    .mode_i  (mode_w),
    .ref_i   (ref_i),
    .above_o (above_w)
  );

  lspwm_gates #(.BRIDGES(BRIDGES), .LVL_W(LVL_W)) u_gates (
    .clk     (clk),
    .rst     (rst),
    .above_i (above_w),
    .gate_o  (gate_o),
    .level_o (level_o)
  );
endmodule

// File: rtl/lspwm_phase_chk.sv
module lspwm_phase_chk #(
  parameter int HALF_W  = 13,
  parameter int BRIDGES = 2,
  parameter int LVL_W   = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic [HALF_W-1:0]       tri_w,
  input logic [HALF_W-1:0]       half_w,
  input logic                    dn_w,
  input logic [1:0]              mode_w,
  input logic [2*BRIDGES-1:0]    above_w,
  input logic signed [LVL_W-1:0] level_o
);
  localparam int BANDS = 2 * BRIDGES;

  p_tri_bound_r2: assert property (@(posedge clk) disable iff (rst)
    tri_w <= half_w);

  p_valley_rises_r2: assert property (@(posedge clk) disable iff (rst)
    (tri_w == '0) |-> !dn_w);

  p_thermo_r3: assert property (@(posedge clk) disable iff (rst)
    ((above_w + BANDS'(1)) & above_w) == '0);

  p_level_count_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (int'(level_o) == $countones($past(above_w)) - BRIDGES));

  p_level_range_r7: assert property (@(posedge clk) disable iff (rst)
    (int'(level_o) >= -BRIDGES) && (int'(level_o) <= BRIDGES));

  p_cfg_at_valley_r10: assert property (@(posedge clk) disable iff (rst)
    ((mode_w != $past(mode_w)) || (half_w != $past(half_w))) |-> (tri_w == '0));
endmodule

bind lspwm_phase lspwm_phase_chk #(
  .HALF_W (HALF_W),
  .BRIDGES(BRIDGES),
  .LVL_W  (LVL_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .tri_w  (tri_w),
  .half_w (half_w),
  .dn_w   (dn_w),
  .mode_w (mode_w),
  .above_w(above_w),
  .level_o(level_o)
);

// File: tb/lspwm_phase_test.sv
module lspwm_phase_test;
  localparam int HALF_W = 13;
  localparam int REF_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        mode_i = 2'd0;
  logic [HALF_W-1:0] half_i = 13'd4;
  logic [REF_W-1:0]  ref_i = 16'd6;
  logic [7:0]        gate_o;
  logic signed [3:0] level_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lspwm_phase uut (
    .clk    (clk),
    .rst    (rst),
    .mode_i (mode_i),
    .half_i (half_i),
    .ref_i  (ref_i),
    .gate_o (gate_o),
    .level_o(level_o)
  );

  // Reference model built from the requirements.
  int        ph, h_m, mode_m, exp_level;
  logic [7:0] exp_gate;

  function automatic int tri_of(int p, int h);
    return (p <= h) ? p : 2 * h - p;
  endfunction

  function automatic int count_above(int r, int t, int h, int m);
    int n = 0;
    for (int k = 0; k < 4; k++) begin
      bit inv = (m == 1) ? (k < 2) : (m == 2) ? (k % 2 == 1) : 1'b0;
      int car = k * h + (inv ? h - t : t);
      if (r > car) n++;
    end
    return n;
  endfunction

  function automatic logic [7:0] gate_of(int n);
    logic [7:0] g;
    for (int j = 0; j < 2; j++) begin
      int c = n - 2 * j;
      if (c < 0) c = 0;
      if (c > 2) c = 2;
      c = c - 1;
      g[4*j+0] = (c == 1);
      g[4*j+1] = !(c == 1);
      g[4*j+2] = (c == -1);
      g[4*j+3] = !(c == -1);
    end
    return g;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ph        <= 0;
      h_m       <= (half_i == 0) ? 1 : int'(half_i);
      mode_m    <= int'(mode_i);
      exp_level <= 0;
      exp_gate  <= 8'hAA;
    end else begin
      exp_level <= count_above(int'(ref_i), tri_of(ph, h_m), h_m, mode_m) - 2;
      exp_gate  <= gate_of(count_above(int'(ref_i), tri_of(ph, h_m), h_m, mode_m));
      if (ph + 1 == 2 * h_m) begin
        ph     <= 0;
        h_m    <= (half_i == 0) ? 1 : int'(half_i);
        mode_m <= int'(mode_i);
      end else begin
        ph <= ph + 1;
      end
    end
  end

  task automatic check_int(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  // Runs n cycles, comparing outputs with the model each cycle.
  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_int(tag, "level", int'(level_o), exp_level);
      check_int("R8", "gates", int'(gate_o), int'(exp_gate));
      check_int("R9", "leg pairs complementary",
                int'((gate_o[0] ^ gate_o[1]) & (gate_o[2] ^ gate_o[3]) &
                     (gate_o[4] ^ gate_o[5]) & (gate_o[6] ^ gate_o[7])), 1);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; half_i = 13'd4; mode_i = 2'd0; ref_i = 16'd6;
    repeat (3) @(negedge clk);
    check_int("R1", "reset level", int'(level_o), 0);
    check_int("R1", "reset gates", int'(gate_o), 8'hAA);
    rst = 1'b0;
  endtask

  task automatic t_in_phase;
    ref_i = 16'd6;  run(16, "R4");
    ref_i = 16'd0;  run(8, "R7");
    check_int("R7", "floor level", int'(level_o), -2);
    ref_i = 16'd16; run(8, "R3");
    ref_i = 16'd17; run(8, "R7");
    check_int("R7", "ceiling level", int'(level_o), 2);
  endtask

  task automatic t_opposition;
    mode_i = 2'd1;
    ref_i = 16'd10; run(16, "R5");
    ref_i = 16'd5;  run(16, "R5");
    ref_i = 16'd3;  run(8, "R5");
  endtask

  task automatic t_alternate;
    mode_i = 2'd2;
    ref_i = 16'd5;  run(16, "R6");
    ref_i = 16'd9;  run(8, "R6");
    ref_i = 16'd13; run(8, "R6");
    mode_i = 2'd3;
    ref_i = 16'd7;  run(16, "R4");
  endtask

  task automatic t_mid_change;
    mode_i = 2'd0; ref_i = 16'd5; run(19, "R10");
    mode_i = 2'd1; run(16, "R10");
    mode_i = 2'd2; run(13, "R10");
  endtask

  task automatic t_period;
    ref_i = 16'd9;
    run(3, "R2");
    half_i = 13'd3; run(20, "R2");
    half_i = 13'd0; ref_i = 16'd3; run(8, "R2");
    half_i = 13'd5; run(12, "R2");
  endtask

  task automatic t_ramp;
    mode_i = 2'd2;
    for (int v = 0; v <= 24; v++) begin
      ref_i = 16'(v);
      run(1, "R7");
    end
    mode_i = 2'd1;
    for (int v = 24; v >= 0; v--) begin
      ref_i = 16'(v);
      run(1, "R7");
    end
  endtask

  initial begin
    t_reset();
    t_in_phase();
    t_opposition();
    t_alternate();
    t_mid_change();
    t_period();
    t_ramp();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule